// File: doc/BRIEF.md
# Merge-Point State Metric and Soft-Output Unit

This block sits where the forward and backward recursions of a sliding-window max-log soft-output detector meet. For one trellis step it takes the forward state metrics, the backward state metrics and the branch metrics already computed for every transition. Metrics are unsigned costs, so a smaller value means more likely. The block combines each transition's three metrics into an extended metric. It then finds the cheapest transition among those driven by a +1 symbol and among those driven by a −1 symbol, and subtracts the two minima to form a signed log-likelihood ratio.

Alongside this, the block carries out the minimum-selecting add-compare-select update used along the recursions. It produces the next forward state metrics and one survivor decision per state. Every adder clamps at the largest metric code, so the metrics never wrap and need no periodic renormalisation. The soft-output path has two register stages: a compare-select tree, then the subtraction.

Top module: `llr_merge_unit`

## Requirements
- R1: While reset is high and after its release until the first valid input, every output is zero: both valid flags, the state metrics, the decisions, the extended metrics and the soft output.
- R2: Trellis numbering: transition t = 2*s + b leaves state s with input bit b, where b = 1 is the +1 symbol and b = 0 the −1 symbol, and enters state t mod S. State s occupies bits [s*MW +: MW] of the state metric buses, and transition t bits [t*MW +: MW] of the branch and extended metric buses.
- R3: Every addition saturates at 2^MW − 1 and never wraps.
- R4: One cycle after a valid input, the extended metric of transition t equals sat(sat(fwd[s] + bm[t]) + bwd[t mod S]).
- R5: One cycle after a valid input, the updated metric of state j is the smaller of sat(fwd[s] + bm[t]) over its two incoming transitions. Decision bit j is 1 when the winning predecessor is from the upper half of the states (s ≥ S/2).
- R6: Two cycles after a valid input, the soft output equals the minimum extended metric over −1 transitions minus the minimum over +1 transitions. It is a two's-complement value MW+1 bits wide, and a positive value favours +1.
- R7: The metric valid flag follows the input valid by one cycle, and the soft-output valid flag follows it by two cycles. A new input may be accepted on every cycle.
- R8: On a cycle with the input valid low, the inputs are ignored. The metric and decision outputs hold their values, and the soft output holds once the pipeline has drained.
- R9: When the two incoming candidates of a state are equal, the lower-indexed transition wins and the decision bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input metrics valid this cycle |
| fwd_sm_i | input | S*MW | Forward state metrics, state s at [s*MW +: MW] |
| bwd_sm_i | input | S*MW | Backward state metrics |
| bm_i | input | 2*S*MW | Branch metrics, transition t at [t*MW +: MW] |
| acs_valid_o | output | 1 | Updated metrics, decisions and extended metrics valid |
| acs_sm_o | output | S*MW | Updated forward state metrics |
| acs_dec_o | output | S | Survivor decision per state |
| ext_o | output | 2*S*MW | Extended metric per transition |
| llr_valid_o | output | 1 | Soft output valid |
| llr_o | output | MW+1 | Signed soft output |

## Verification
The assertions check, on every cycle, the valid-flag latencies and that no extended metric falls below any of its three summands, which is how a wrapped sum shows up. They also check that every updated state metric is at least the smaller of its incoming branch metrics, that a tie clears the decision bit, that the soft output stays within the range of the metric difference, and that the outputs hold while the input valid is low. Only the bench's scenarios can show the exact arithmetic values. The same holds for the sign convention of the soft output, full saturation in every path, and the mapping of transitions onto states and decisions. These are compared against a behavioural model on each clock and tried with directed and random patterns.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int unsigned DEF_MW = 8;
    localparam int unsigned DEF_NU = 2;

    typedef struct packed {
        logic acs_v;
        logic llr_v;
    } stage_ctl_t;

    // Clamped addition on operands zero-extended to 32 bits.
    function automatic logic [31:0] sat_sum(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] cap);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s > {1'b0, cap})
            return cap;
        return s[31:0];
    endfunction
endpackage

// File: rtl/mm_ext_gen.sv
module mm_ext_gen #(
    parameter int unsigned MW = mm_pkg::DEF_MW,
    parameter int unsigned NU = mm_pkg::DEF_NU
) (
    input  logic [(1<<NU)*MW-1:0]   fwd,
    input  logic [(1<<NU)*MW-1:0]   bwd,
    input  logic [2*(1<<NU)*MW-1:0] bm,
    output logic [2*(1<<NU)*MW-1:0] ext
);
    localparam int unsigned S = 1 << NU;
    localparam int unsigned T = 2 * S;
    localparam logic [31:0] CAP = (32'd1 << MW) - 32'd1;

    for (genvar t = 0; t < T; t++) begin : g_tr
        localparam int unsigned SRC = t / 2;
        localparam int unsigned NXT = t % S;
        logic [MW-1:0] head;
        assign head = MW'(mm_pkg::sat_sum(32'(fwd[SRC*MW +: MW]), 32'(bm[t*MW +: MW]), CAP));
        assign ext[t*MW +: MW] = MW'(mm_pkg::sat_sum(32'(head), 32'(bwd[NXT*MW +: MW]), CAP));
    end
endmodule

// File: rtl/mm_acs.sv
module mm_acs #(
    parameter int unsigned MW = mm_pkg::DEF_MW,
    parameter int unsigned NU = mm_pkg::DEF_NU
) (
    input  logic [(1<<NU)*MW-1:0]   fwd,
    input  logic [2*(1<<NU)*MW-1:0] bm,
    output logic [(1<<NU)*MW-1:0]   sm,
    output logic [(1<<NU)-1:0]      dec
);
    localparam int unsigned S = 1 << NU;
    localparam logic [31:0] CAP = (32'd1 << MW) - 32'd1;

    for (genvar j = 0; j < S; j++) begin : g_st
        localparam int unsigned B  = j % 2;
        localparam int unsigned P0 = j / 2;
        localparam int unsigned P1 = P0 + S / 2;
        localparam int unsigned T0 = 2 * P0 + B;
        localparam int unsigned T1 = 2 * P1 + B;
        logic [MW-1:0] c_lo, c_hi;
        assign c_lo = MW'(mm_pkg::sat_sum(32'(fwd[P0*MW +: MW]), 32'(bm[T0*MW +: MW]), CAP));
        assign c_hi = MW'(mm_pkg::sat_sum(32'(fwd[P1*MW +: MW]), 32'(bm[T1*MW +: MW]), CAP));
        // strict compare: lower-indexed transition wins a tie
        assign dec[j] = (c_hi < c_lo);
        assign sm[j*MW +: MW] = dec[j] ? c_hi : c_lo;
    end
endmodule

// File: rtl/mm_min_tree.sv
module mm_min_tree #(
    parameter int unsigned MW = mm_pkg::DEF_MW,
    parameter int unsigned N  = 4
) (
    input  logic [N*MW-1:0] vals,
    output logic [MW-1:0]   vmin
);
    // heap layout: leaves at N-1 .. 2N-2, root at 0
    localparam int unsigned NODES = 2 * N - 1;
    logic [MW-1:0] node [NODES];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N-1+i] = vals[i*MW +: MW];
    end
    for (genvar i = 0; i < N - 1; i++) begin : g_cs
        assign node[i] = (node[2*i+2] < node[2*i+1]) ? node[2*i+2] : node[2*i+1];
    end
    assign vmin = node[0];
endmodule

// File: rtl/llr_merge_unit.sv
module llr_merge_unit #(
    parameter int unsigned MW = mm_pkg::DEF_MW,
    parameter int unsigned NU = mm_pkg::DEF_NU
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [(1<<NU)*MW-1:0]   fwd_sm_i,
    input  logic [(1<<NU)*MW-1:0]   bwd_sm_i,
    input  logic [2*(1<<NU)*MW-1:0] bm_i,
    output logic                    acs_valid_o,
    output logic [(1<<NU)*MW-1:0]   acs_sm_o,
    output logic [(1<<NU)-1:0]      acs_dec_o,
    output logic [2*(1<<NU)*MW-1:0] ext_o,
    output logic                    llr_valid_o,
    output logic [MW:0]             llr_o
);
    localparam int unsigned S = 1 << NU;
    localparam int unsigned T = 2 * S;

    logic [T*MW-1:0] ext_c;
    logic [S*MW-1:0] acs_c;
    logic [S-1:0]    dec_c;
    logic [S*MW-1:0] plus_v, minus_v;
    logic [MW-1:0]   minp_c, minm_c;

    mm_pkg::stage_ctl_t ctl_q;
    logic [S*MW-1:0]    acs_q;
    logic [S-1:0]       dec_q;
    logic [T*MW-1:0]    ext_q;
    logic [MW-1:0]      minp_q, minm_q;
    logic [MW:0]        llr_q;

    mm_ext_gen #(.MW(MW), .NU(NU)) u_ext (
        .fwd (fwd_sm_i),
        .bwd (bwd_sm_i),
        .bm  (bm_i),
        .ext (ext_c)
    );

    mm_acs #(.MW(MW), .NU(NU)) u_acs (
        .fwd (fwd_sm_i),
        .bm  (bm_i),
        .sm  (acs_c),
        .dec (dec_c)
    );

    // split transitions by input bit: odd index = +1, even index = -1
    for (genvar k = 0; k < S; k++) begin : g_grp
        assign plus_v[k*MW +: MW]  = ext_c[(2*k+1)*MW +: MW];
        assign minus_v[k*MW +: MW] = ext_c[(2*k)*MW +: MW];
    end

    mm_min_tree #(.MW(MW), .N(S)) u_min_plus (
        .vals (plus_v),
        .vmin (minp_c)
    );

    mm_min_tree #(.MW(MW), .N(S)) u_min_minus (
        .vals (minus_v),
        .vmin (minm_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            acs_q  <= '0;
            dec_q  <= '0;
            ext_q  <= '0;
            minp_q <= '0;
            minm_q <= '0;
            llr_q  <= '0;
        end else begin
            ctl_q.acs_v <= in_valid;
            ctl_q.llr_v <= ctl_q.acs_v;
            if (in_valid) begin
                acs_q  <= acs_c;
                dec_q  <= dec_c;
                ext_q  <= ext_c;
                minp_q <= minp_c;
                minm_q <= minm_c;
            end
            if (ctl_q.acs_v)
                llr_q <= $signed({1'b0, minm_q}) - $signed({1'b0, minp_q});
        end
    end

    assign acs_valid_o = ctl_q.acs_v;
    assign acs_sm_o    = acs_q;
    assign acs_dec_o   = dec_q;
    assign ext_o       = ext_q;
    assign llr_valid_o = ctl_q.llr_v;
    assign llr_o       = llr_q;
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
    parameter int unsigned MW = mm_pkg::DEF_MW,
    parameter int unsigned NU = mm_pkg::DEF_NU
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [(1<<NU)*MW-1:0]   fwd_sm_i,
    input logic [(1<<NU)*MW-1:0]   bwd_sm_i,
    input logic [2*(1<<NU)*MW-1:0] bm_i,
    input logic                    acs_valid_o,
    input logic [(1<<NU)*MW-1:0]   acs_sm_o,
    input logic [(1<<NU)-1:0]      acs_dec_o,
    input logic [2*(1<<NU)*MW-1:0] ext_o,
    input logic                    llr_valid_o,
    input logic [MW:0]             llr_o
);
    localparam int unsigned S = 1 << NU;
    localparam int unsigned T = 2 * S;
    localparam int MAXV = (1 << MW) - 1;

    p_acs_lat_r7: assert property (@(posedge clk) disable iff (rst)
        acs_valid_o == $past(in_valid));

    p_llr_lat_r7: assert property (@(posedge clk) disable iff (rst)
        llr_valid_o == $past(acs_valid_o));

    p_llr_range_r6: assert property (@(posedge clk) disable iff (rst)
        llr_valid_o |-> (int'($signed(llr_o)) <= MAXV && int'($signed(llr_o)) >= -MAXV));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(ext_o) && $stable(acs_sm_o) && $stable(acs_dec_o)));

    for (genvar t = 0; t < T; t++) begin : g_ext_chk
        localparam int unsigned SRC = t / 2;
        localparam int unsigned NXT = t % S;
        // a wrapped sum would drop below one of its summands (R3)
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (acs_valid_o && $past(in_valid)) |->
                (ext_o[t*MW +: MW] >= $past(bm_i[t*MW +: MW]) &&
                 ext_o[t*MW +: MW] >= $past(fwd_sm_i[SRC*MW +: MW]) &&
                 ext_o[t*MW +: MW] >= $past(bwd_sm_i[NXT*MW +: MW])));
    end

    for (genvar j = 0; j < S; j++) begin : g_acs_chk
        localparam int unsigned B  = j % 2;
        localparam int unsigned P0 = j / 2;
        localparam int unsigned P1 = P0 + S / 2;
        localparam int unsigned T0 = 2 * P0 + B;
        localparam int unsigned T1 = 2 * P1 + B;
        p_acs_floor_r5: assert property (@(posedge clk) disable iff (rst)
            (acs_valid_o && $past(in_valid)) |->
                (acs_sm_o[j*MW +: MW] >= $past(bm_i[T0*MW +: MW]) ||
                 acs_sm_o[j*MW +: MW] >= $past(bm_i[T1*MW +: MW])));
        p_tie_low_r9: assert property (@(posedge clk) disable iff (rst)
            (acs_valid_o && $past(in_valid) &&
             $past(fwd_sm_i[P0*MW +: MW]) == $past(fwd_sm_i[P1*MW +: MW]) &&
             $past(bm_i[T0*MW +: MW]) == $past(bm_i[T1*MW +: MW])) |-> !acs_dec_o[j]);
    end
endmodule

bind llr_merge_unit mm_checker #(.MW(MW), .NU(NU)) u_chk (.*);

// File: tb/llr_merge_unit_bench.sv
module llr_merge_unit_bench;
    localparam int MW = 8;
    localparam int NU = 2;
    localparam int S = 1 << NU;
    localparam int T = 2 * S;
    localparam int MAXV = (1 << MW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [S*MW-1:0] fwd = '0, bwd = '0;
    logic [T*MW-1:0] bm = '0;
    logic acs_valid_o, llr_valid_o;
    logic [S*MW-1:0] acs_sm_o;
    logic [S-1:0] acs_dec_o;
    logic [T*MW-1:0] ext_o;
    logic [MW:0] llr_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    llr_merge_unit #(.MW(MW), .NU(NU)) u_llr_merge_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .fwd_sm_i(fwd), .bwd_sm_i(bwd), .bm_i(bm),
        .acs_valid_o(acs_valid_o), .acs_sm_o(acs_sm_o), .acs_dec_o(acs_dec_o),
        .ext_o(ext_o), .llr_valid_o(llr_valid_o), .llr_o(llr_o)
    );

    function automatic int rsat(int a, int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction
    function automatic int fm(int s); return int'(fwd[s*MW +: MW]); endfunction
    function automatic int bwm(int s); return int'(bwd[s*MW +: MW]); endfunction
    function automatic int gm(int t); return int'(bm[t*MW +: MW]); endfunction

    // behavioural reference model
    int e_ext[T];
    int e_acs[S];
    int e_dec[S];
    int e_mp, e_mm, e_llr;
    bit e_av, e_lv;

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < T; t++) e_ext[t] <= 0;
            for (int j = 0; j < S; j++) begin e_acs[j] <= 0; e_dec[j] <= 0; end
            e_mp <= 0; e_mm <= 0; e_llr <= 0; e_av <= 0; e_lv <= 0;
        end else begin
            e_av <= in_valid;
            e_lv <= e_av;
            if (e_av) e_llr <= e_mm - e_mp;
            if (in_valid) begin
                int bp, bmn;
                bp = MAXV + 1; bmn = MAXV + 1;
                for (int t = 0; t < T; t++) begin
                    int v;
                    v = rsat(rsat(fm(t / 2), gm(t)), bwm(t % S));
                    e_ext[t] <= v;
                    if (t % 2 == 1) begin if (v < bp) bp = v; end
                    else begin if (v < bmn) bmn = v; end
                end
                e_mp <= bp; e_mm <= bmn;
                for (int j = 0; j < S; j++) begin
                    int best, bsrc;
                    best = MAXV + 1; bsrc = 0;
                    for (int t = 0; t < T; t++) begin
                        if (t % S == j && rsat(fm(t / 2), gm(t)) < best) begin
                            best = rsat(fm(t / 2), gm(t));
                            bsrc = t / 2;
                        end
                    end
                    e_acs[j] <= best;
                    e_dec[j] <= (bsrc >= S / 2) ? 1 : 0;
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R7 acs_valid", int'(acs_valid_o), int'(e_av));
            chk("R7 llr_valid", int'(llr_valid_o), int'(e_lv));
            for (int t = 0; t < T; t++) chk("R4 ext", int'(ext_o[t*MW +: MW]), e_ext[t]);
            for (int j = 0; j < S; j++) begin
                chk("R5 acs metric", int'(acs_sm_o[j*MW +: MW]), e_acs[j]);
                chk("R9 decision", int'(acs_dec_o[j]), e_dec[j]);
            end
            chk("R6 llr", int'($signed(llr_o)), e_llr);
        end
    end

    task automatic fill(int f, int b, int g);
        for (int i = 0; i < S; i++) begin
            fwd[i*MW +: MW] = MW'(f);
            bwd[i*MW +: MW] = MW'(b);
        end
        for (int t = 0; t < T; t++) bm[t*MW +: MW] = MW'(g);
    endtask

    task automatic randomize_in();
        for (int i = 0; i < S; i++) begin
            fwd[i*MW +: MW] = MW'($urandom_range(0, MAXV));
            bwd[i*MW +: MW] = MW'($urandom_range(0, MAXV));
        end
        for (int t = 0; t < T; t++) bm[t*MW +: MW] = MW'($urandom_range(0, MAXV));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int snap_ext, snap_acs, snap_llr;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 acs_valid", int'(acs_valid_o), 0);
        chk("R1 llr_valid", int'(llr_valid_o), 0);
        chk("R1 llr", int'($signed(llr_o)), 0);
        chk("R1 ext", int'(ext_o != '0), 0);
        chk("R1 acs", int'(acs_sm_o != '0), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'(acs_valid_o | llr_valid_o), 0);

        // R2: only transition 5 (state 2, bit +1) is cheap -> positive llr
        fill(0, 0, 40);
        bm[5*MW +: MW] = MW'(1);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 ext t5", int'(ext_o[5*MW +: MW]), 1);
        chk("R2 ext t4", int'(ext_o[4*MW +: MW]), 40);
        chk("R2 acs state1", int'(acs_sm_o[1*MW +: MW]), 1);
        chk("R2 dec state1", int'(acs_dec_o[1]), 1);
        @(negedge clk);
        chk("R2 llr sign", int'($signed(llr_o)), 39);

        // R3: saturation everywhere, equal candidates (R9)
        fill(200, 250, 100);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 ext saturated", int'(ext_o[3*MW +: MW]), MAXV);
        chk("R3 acs saturated", int'(acs_sm_o[2*MW +: MW]), MAXV);
        chk("R9 tie decisions", int'(acs_dec_o), 0);
        @(negedge clk);
        chk("R3 llr at saturation", int'($signed(llr_o)), 0);

        // R6: negative llr, -1 transition 2 cheap
        fill(10, 10, 90);
        bm[2*MW +: MW] = MW'(0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R6 llr negative", int'($signed(llr_o)), 20 - 110);

        // R8: inputs ignored while in_valid is low
        snap_ext = int'(ext_o[0 +: MW]);
        snap_acs = int'(acs_sm_o[0 +: MW]);
        snap_llr = int'($signed(llr_o));
        for (int k = 0; k < 4; k++) begin
            randomize_in();
            @(negedge clk);
        end
        chk("R8 ext held", int'(ext_o[0 +: MW]), snap_ext);
        chk("R8 acs held", int'(acs_sm_o[0 +: MW]), snap_acs);
        chk("R8 llr held", int'($signed(llr_o)), snap_llr);

        // R7: back-to-back and random traffic, model compared each cycle
        for (int k = 0; k < 400; k++) begin
            randomize_in();
            if (k % 5 == 0) fill($urandom_range(150, MAXV), $urandom_range(150, MAXV), $urandom_range(100, MAXV));
            in_valid = (k < 40) ? 1'b1 : 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule